// File: doc/BRIEF.md
# Flagless Rotate-Right Execution Slice

This block executes a rotate-right-by-immediate operation inside an integer pipeline. It takes a 64-bit source operand, an 8-bit immediate count, the current processor mode and the W and L bits of the vector-extension prefix. From these it picks the operand width, masks the count to that width and rotates the operand. The operation never writes the arithmetic flags. When the operation is illegal it reports an undefined-opcode fault instead of a result.

Operands are captured on a start strobe. One clock later the block presents either a valid result or a fault strobe, never both. The result register keeps its value until the next start. Fetching operands from memory, writing back to the register file and decoding the full instruction are left to the surrounding pipeline.

Top module: `rotr_unit`

## Requirements
- R1: With a 32-bit operand, the rotate amount is the immediate AND 0x1F. Immediate bits 7 to 5 have no effect.
- R2: With a 64-bit operand, the rotate amount is the immediate AND 0x3F. Immediate bits 7 and 6 have no effect.
- R3: For an operand of width S and a masked amount c, result bit i equals source bit (i + c) mod S, for every i below S.
- R4: A masked amount of zero returns the operand unchanged. This holds for a 64-bit operand and also for the low 32 bits of a 32-bit operand.
- R5: With a 32-bit operand, source bits 63 to 32 take no part in the result, and result bits 63 to 32 are zero.
- R6: mode_i uses this encoding: 2'b00 real, 2'b01 virtual-8086, 2'b10 protected/compatibility, 2'b11 64-bit. In mode 2'b11, vex_w_i=1 selects a 64-bit operand and vex_w_i=0 selects a 32-bit operand. In mode 2'b10 the operand is 32 bits whatever vex_w_i is.
- R7: A start with vex_l_i=1 raises fault_o one cycle later. In that cycle valid_o is low and result_o is zero.
- R8: A start in mode 2'b00 or 2'b01 raises fault_o one cycle later. In that cycle valid_o is low and result_o is zero.
- R9: A legal start raises valid_o for exactly the next cycle. valid_o and fault_o are never high together. While start_i is low, result_o holds its value and both strobes stay low.
- R10: flag_wr_en_o is 0 at all times, for every input.
- R11: A synchronous active-low reset (rst_n low at a clock edge) clears valid_o, fault_o and result_o. This includes the case where start_i is high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Capture the operands and issue the operation |
| src_i | input | 64 | Source operand |
| imm_i | input | 8 | Immediate rotate count |
| mode_i | input | 2 | Processor mode (encoding in R6) |
| vex_w_i | input | 1 | Operand-width bit of the prefix |
| vex_l_i | input | 1 | Vector-length bit of the prefix; must be 0 |
| result_o | output | 64 | Rotated result, zero-extended for 32-bit operands |
| valid_o | output | 1 | Result strobe, one cycle after a legal start |
| fault_o | output | 1 | Undefined-opcode strobe, one cycle after an illegal start |
| flag_wr_en_o | output | 1 | Arithmetic-flag write enable, always 0 |

## Verification
Two cases are hard to reach from the ports. The first is an immediate whose dropped high bits are set while the masked amount is zero, such as 0x40 with a 64-bit operand or 0x20 with a 32-bit one. The second is W=1 in a mode where it must be ignored. A careless mask or width choice turns either case into a full-width shift or a 64-bit rotate. The vector table pairs source patterns that have distinct upper and lower halves with exactly these immediates and mode/W combinations. A reference model in the bench builds each result bit by modular indexing. Directed steps then raise reset while a start is pending and idle the block between operations to expose any register that is not held.

// File: rtl/rotr_pkg.sv
// Package: shared types for the flagless rotate slice.
// Assumes: the mode input carries the two-bit encoding listed below.
package rotr_pkg;

    // Processor operating modes, as driven on mode_i
    typedef enum logic [1:0] {
        MODE_REAL = 2'b00,
        MODE_VIRT = 2'b01,
        MODE_PROT = 2'b10,
        MODE_LONG = 2'b11
    } cpu_mode_e;

endpackage

// File: rtl/rotr_decode.sv
// Module: rotr_decode
// Chooses the operand width from mode and W, masks the count to that width,
// and flags illegal combinations (L set, or a legacy real/virtual mode).
// Assumes: IMM_W >= CNT_W. Purely combinational.
module rotr_decode
    import rotr_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int IMM_W    = 8,
    localparam int CNT_W   = $clog2(DATA_W),
    localparam int NCNT_W  = $clog2(NARROW_W)
) (
    input  logic [1:0]       mode_i,
    input  logic             vex_w_i,
    input  logic             vex_l_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic             narrow_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fault_o,
    output logic             flag_we_o
);

    cpu_mode_e mode;
    logic      legacy_mode;
    logic      unused_imm_hi;

    assign mode = cpu_mode_e'(mode_i);

    // Width select: W matters only in the 64-bit mode
    always_comb begin
        narrow_o = !((mode == MODE_LONG) && vex_w_i);
    end

    // Count mask: keep only as many bits as the operand width needs
    always_comb begin
        cnt_o = '0;
        if (narrow_o) begin
            cnt_o[NCNT_W-1:0] = imm_i[NCNT_W-1:0];
        end else begin
            cnt_o = imm_i[CNT_W-1:0];
        end
    end

    // Legality: legacy modes and a nonzero L both yield undefined opcode
    always_comb begin
        legacy_mode = (mode == MODE_REAL) || (mode == MODE_VIRT);
        fault_o     = legacy_mode || vex_l_i;
    end

    // This operation class never writes the arithmetic flags
    assign flag_we_o = 1'b0;

    assign unused_imm_hi = &{1'b0, imm_i[IMM_W-1:CNT_W]};

endmodule

// File: rtl/rotr_barrel.sv
// Module: rotr_barrel
// Logarithmic rotate-right network. In narrow mode it rotates within the
// low NARROW_W bits and zero-fills the upper bits. A zero count is the
// identity, and no stage shifts by the full width.
// Assumes: in narrow mode, count bits at or above log2(NARROW_W) are zero.
module rotr_barrel #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    localparam int CNT_W   = $clog2(DATA_W),
    localparam int NCNT_W  = $clog2(NARROW_W),
    localparam int PAD_W   = DATA_W - NARROW_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              narrow_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] stg [CNT_W+1];

    // Stage 0: drop the upper half for narrow operands
    always_comb begin
        stg[0] = narrow_i ? {{PAD_W{1'b0}}, data_i[NARROW_W-1:0]} : data_i;
    end

    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        localparam int AMT = 1 << k;
        logic [DATA_W-1:0] wide_rot;
        logic [DATA_W-1:0] narrow_rot;

        assign wide_rot = {stg[k][AMT-1:0], stg[k][DATA_W-1:AMT]};

        if (k < NCNT_W) begin : g_nrot
            assign narrow_rot = {{PAD_W{1'b0}}, stg[k][AMT-1:0], stg[k][NARROW_W-1:AMT]};
        end else begin : g_npass
            assign narrow_rot = stg[k];
        end

        // Apply this power-of-two step when its count bit is set
        always_comb begin
            if (cnt_i[k]) begin
                stg[k+1] = narrow_i ? narrow_rot : wide_rot;
            end else begin
                stg[k+1] = stg[k];
            end
        end
    end

    assign data_o = stg[CNT_W];

endmodule

// File: rtl/rotr_unit.sv
// Module: rotr_unit (top)
// Rotate-right-by-immediate slice. Operands are captured on start_i, and the
// result or the fault appears one clock later. The flag write enable is never set.
// Assumes: synchronous active-low reset; result is zero on a fault.
module rotr_unit #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int IMM_W    = 8,
    localparam int CNT_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [1:0]        mode_i,
    input  logic              vex_w_i,
    input  logic              vex_l_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              fault_o,
    output logic              flag_wr_en_o
);

    logic              narrow;
    logic [CNT_W-1:0]  cnt;
    logic              illegal;
    logic [DATA_W-1:0] rotated;

    rotr_decode #(
        .DATA_W  (DATA_W),
        .NARROW_W(NARROW_W),
        .IMM_W   (IMM_W)
    ) i_decode (
        .mode_i   (mode_i),
        .vex_w_i  (vex_w_i),
        .vex_l_i  (vex_l_i),
        .imm_i    (imm_i),
        .narrow_o (narrow),
        .cnt_o    (cnt),
        .fault_o  (illegal),
        .flag_we_o(flag_wr_en_o)
    );

    rotr_barrel #(
        .DATA_W  (DATA_W),
        .NARROW_W(NARROW_W)
    ) i_barrel (
        .data_i  (src_i),
        .cnt_i   (cnt),
        .narrow_i(narrow),
        .data_o  (rotated)
    );

    // Output register: capture the outcome on start, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            valid_o  <= 1'b0;
            fault_o  <= 1'b0;
        end else begin
            valid_o <= start_i && !illegal;
            fault_o <= start_i && illegal;
            if (start_i) begin
                result_o <= illegal ? '0 : rotated;
            end
        end
    end

endmodule

// File: rtl/rotr_unit_chk.sv
// Module: rotr_unit_chk
// Protocol and corner-case properties for rotr_unit, bound to every instance.
// Assumes: the mode encoding of rotr_pkg.
module rotr_unit_chk #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32,
    parameter int IMM_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [DATA_W-1:0] src_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [1:0]        mode_i,
    input logic              vex_w_i,
    input logic              vex_l_i,
    input logic [DATA_W-1:0] result_o,
    input logic              valid_o,
    input logic              fault_o,
    input logic              flag_wr_en_o
);
    localparam int CNT_W = $clog2(DATA_W);

    logic unused_flag;
    assign unused_flag = flag_wr_en_o;

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && fault_o)); // R9

    AST_STROBE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o && !fault_o && $stable(result_o)); // R9

    AST_L_BIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && vex_l_i |=> fault_o && !valid_o && (result_o == '0)); // R7

    AST_LEGACY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !mode_i[1] |=> fault_o && !valid_o && (result_o == '0)); // R8

    AST_ZERO_COUNT_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && (mode_i == 2'b11) && vex_w_i && !vex_l_i && (imm_i[CNT_W-1:0] == '0)
        |=> valid_o && (result_o == $past(src_i))); // R4

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && mode_i[1] && !(mode_i[0] && vex_w_i) && !vex_l_i
        |=> valid_o && (result_o[DATA_W-1:NARROW_W] == '0)); // R5

endmodule

bind rotr_unit rotr_unit_chk #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W),
    .IMM_W   (IMM_W)
) i_rotr_unit_chk (.*);

// File: tb/test_rotr_unit.sv
// Bench for rotr_unit: a stimulus table walked by one loop, then directed
// tests for reset, hold and pending-start-under-reset.
module test_rotr_unit;

    typedef struct packed {
        logic [63:0] src;
        logic [7:0]  imm;
        logic [1:0]  mode;
        logic        w;
        logic        l;
        logic        flt;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        {64'h0123_4567_89AB_CDEF, 8'h04, 2'b11, 1'b1, 1'b0, 1'b0}, // R3 64-bit
        {64'h0123_4567_89AB_CDEF, 8'h44, 2'b11, 1'b1, 1'b0, 1'b0}, // R2 mask
        {64'hFFFF_0000_8000_0001, 8'h01, 2'b11, 1'b0, 1'b0, 1'b0}, // R5 R6 W=0
        {64'hDEAD_BEEF_1234_5678, 8'h23, 2'b10, 1'b1, 1'b0, 1'b0}, // R1 R6 W ignored
        {64'hA5A5_0F0F_C3C3_9696, 8'h00, 2'b11, 1'b1, 1'b0, 1'b0}, // R4
        {64'hA5A5_0F0F_C3C3_9696, 8'h40, 2'b11, 1'b1, 1'b0, 1'b0}, // R4 R2
        {64'h7777_8888_CAFE_F00D, 8'h20, 2'b10, 1'b0, 1'b0, 1'b0}, // R4 R1
        {64'h8000_0000_0000_0001, 8'h3F, 2'b11, 1'b1, 1'b0, 1'b0}, // R3
        {64'h1111_2222_8000_0001, 8'h1F, 2'b10, 1'b0, 1'b0, 1'b0}, // R3 R5
        {64'h0123_4567_89AB_CDEF, 8'h05, 2'b00, 1'b0, 1'b0, 1'b1}, // R8 real
        {64'h0123_4567_89AB_CDEF, 8'h05, 2'b01, 1'b1, 1'b0, 1'b1}, // R8 virtual
        {64'h0123_4567_89AB_CDEF, 8'h05, 2'b11, 1'b1, 1'b1, 1'b1}, // R7
        {64'h0123_4567_89AB_CDEF, 8'h05, 2'b10, 1'b0, 1'b1, 1'b1}, // R7
        {64'hF0E1_D2C3_B4A5_9687, 8'hFF, 2'b11, 1'b1, 1'b0, 1'b0}  // R2 R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] src_i = '0;
    logic [7:0]  imm_i = '0;
    logic [1:0]  mode_i = '0;
    logic        vex_w_i = 1'b0;
    logic        vex_l_i = 1'b0;
    logic [63:0] result_o;
    logic        valid_o;
    logic        fault_o;
    logic        flag_wr_en_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rotr_unit i_rotr_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .src_i       (src_i),
        .imm_i       (imm_i),
        .mode_i      (mode_i),
        .vex_w_i     (vex_w_i),
        .vex_l_i     (vex_l_i),
        .result_o    (result_o),
        .valid_o     (valid_o),
        .fault_o     (fault_o),
        .flag_wr_en_o(flag_wr_en_o)
    );

    // Reference model: result bit i takes source bit (i + c) mod S
    function automatic logic [63:0] ref_rot(logic [63:0] s, logic [7:0] imm,
                                            logic [1:0] mode, logic w);
        int sz = (mode == 2'b11 && w) ? 64 : 32;
        int c  = int'(imm) % sz;
        logic [63:0] r = '0;
        for (int i = 0; i < sz; i++) r[i] = s[(i + c) % sz];
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(vec_t v);
        src_i = v.src; imm_i = v.imm; mode_i = v.mode;
        vex_w_i = v.w; vex_l_i = v.l; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 valid after reset", {63'd0, valid_o}, 64'd0);
        chk("R11 fault after reset", {63'd0, fault_o}, 64'd0);
        chk("R11 result after reset", result_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1..R8, R10
        for (int k = 0; k < NVEC; k++) begin
            logic [63:0] exp_r;
            issue(VECS[k]);
            exp_r = VECS[k].flt ? 64'd0 : ref_rot(VECS[k].src, VECS[k].imm, VECS[k].mode, VECS[k].w);
            chk($sformatf("R3 result vec %0d", k), result_o, exp_r);
            chk($sformatf("R9 valid vec %0d", k), {63'd0, valid_o}, {63'd0, !VECS[k].flt});
            chk($sformatf("R7 R8 fault vec %0d", k), {63'd0, fault_o}, {63'd0, VECS[k].flt});
            chk($sformatf("R10 flag enable vec %0d", k), {63'd0, flag_wr_en_o}, 64'd0);
        end

        // R4: zero amount on a wide operand gives the source unchanged
        issue('{src: 64'h0F1E_2D3C_4B5A_6978, imm: 8'hC0, mode: 2'b11, w: 1'b1, l: 1'b0, flt: 1'b0});
        chk("R4 zero count wide", result_o, 64'h0F1E_2D3C_4B5A_6978);
        // R5: upper source bits ignored, one-bit narrow rotate
        issue('{src: 64'hFFFF_FFFF_0000_0001, imm: 8'h01, mode: 2'b10, w: 1'b1, l: 1'b0, flt: 1'b0});
        chk("R5 narrow upper ignored", result_o, 64'h0000_0000_8000_0000);

        // R9: idle cycles hold the result and keep both strobes low
        src_i = 64'hFFFF_FFFF_FFFF_FFFF; imm_i = 8'h07;
        @(negedge clk);
        chk("R9 hold result", result_o, 64'h0000_0000_8000_0000);
        chk("R9 valid low when idle", {63'd0, valid_o}, 64'd0);
        chk("R9 fault low when idle", {63'd0, fault_o}, 64'd0);

        // R11: reset wins over a pending start
        src_i = 64'h1234; imm_i = 8'h01; mode_i = 2'b11; vex_w_i = 1'b1; vex_l_i = 1'b0;
        start_i = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R11 result cleared with start", result_o, 64'd0);
        chk("R11 valid cleared with start", {63'd0, valid_o}, 64'd0);
        chk("R10 flag enable in reset", {63'd0, flag_wr_en_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule